// File: doc/BRIEF.md
# Programmable SDRAM Command Timing Sequencer

This block turns one memory access into the SDRAM command train it needs, with the gaps between commands set by a small set of timing settings. A request carries a page classification (open row hit, bank idle, or another row open), a row, bank and column address, a write flag and a flag that marks a CPU-initiated access. The sequencer then walks through precharge, activate and the column command as the page state requires. It drives chip select, the three active-low command strobes, the bank lines and the multiplexed address. For reads it raises a one-clock strobe when the data should be on the bus.

The timing settings are CAS latency, activate-to-column delay and precharge recovery, each 2 or 3 clocks, plus a leadoff setting. The leadoff setting puts the first chip-select assertion of a CPU read in clock 3 or clock 4. The command strobes and address already show the first command in clock 2, with chip select still high, so the bus has a full clock to settle. Settings are sampled when a request is accepted, and a ready handshake holds off the next request until the current train has finished.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is applied and after its release, `sd_cs_n` is 1, `req_ready` is 1 and `rd_valid` is 0.
- R2: A command is the value of {`sd_ras_n`,`sd_cas_n`,`sd_we_n`} in a clock where `sd_cs_n` is 0: precharge 010, activate 011, read 101, write 100. When `sd_cs_n` is 1 the cycle is a no-operation.
- R3: Page class 01 (hit) issues only the column command: read, or write when `req_write` is 1. It carries the zero-extended column on `sd_addr` and the request bank on `sd_bank`.
- R4: Page class 00 (idle bank) issues activate with the row on `sd_addr`, then the column command exactly tRCD clocks later. tRCD is 2 when `cfg_rcd3` is 0 and 3 when it is 1.
- R5: Page class 10 or 11 (miss) issues precharge with `sd_addr` all zero. Activate follows tRP clocks later, where tRP is 2 when `cfg_rp3` is 0 and 3 when it is 1. Then the R4 sequence runs.
- R6: Clock 1 is the clock after the edge that accepts a request. The first chip-select assertion falls in clock 4 for a CPU read (`req_cpu`=1, `req_write`=0) with `cfg_lead4`=1, and in clock 3 otherwise.
- R7: In clock 2 `sd_cs_n` is 1, and the command strobes already carry the code of the first command of the sequence.
- R8: For a read, `rd_valid` is 1 for exactly one clock, CL clocks after the read command. CL is 2 when `cfg_cas3` is 0 and 3 when it is 1. A write never raises `rd_valid`.
- R9: `sd_cs_n` stays low for one clock per command, and no extra commands are issued.
- R10: The timing settings are captured when a request is accepted. Changing them during an access does not alter that access.
- R11: `req_ready` is 0 from clock 1 until the sequence ends. It is 1 again in the clock after the write command, or in the clock after `rd_valid` for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted on this edge |
| req_page | input | 2 | Page class: 00 idle bank, 01 hit, 1x miss |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cpu | input | 1 | Request initiated by the CPU |
| req_row | input | ROW_W | Row address |
| req_bank | input | BANK_W | Bank address |
| req_col | input | COL_W | Column address |
| cfg_cas3 | input | 1 | CAS latency 3 (else 2) |
| cfg_rcd3 | input | 1 | Activate-to-column delay 3 (else 2) |
| cfg_rp3 | input | 1 | Precharge time 3 (else 2) |
| cfg_lead4 | input | 1 | CPU read leadoff chip select in clock 4 (else 3) |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_bank | output | BANK_W | Bank lines |
| sd_addr | output | ROW_W | Multiplexed address |
| rd_valid | output | 1 | Read data valid strobe |

## Verification
The bench builds the block with its defaults: a 13-bit row, 10-bit column and 2-bit bank. These make every row and column bit visible on the address lines, and the column zero-extension is observable in the upper bits. The four timing settings are inputs rather than parameters, so one build reaches every combination of CAS latency, activate delay, precharge time and leadoff. The tests cover the two extreme corners, the leadoff setting against writes and non-CPU reads, and both miss encodings. Every access flips all four settings one clock after acceptance, which exposes any setting that is used live instead of captured.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_PRE = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT1 = 3'd1,
    ST_SETUP = 3'd2,
    ST_ISSUE = 3'd3,
    ST_GAP   = 3'd4,
    ST_DRAIN = 3'd5
  } st_e;

  typedef struct packed {
    logic cas3;
    logic rcd3;
    logic rp3;
    logic lead4;
  } tcfg_t;

  // {ras_n, cas_n, we_n} for each command
  function automatic logic [2:0] cmd_code(input cmd_e c);
    case (c)
      CMD_PRE: cmd_code = 3'b010;
      CMD_ACT: cmd_code = 3'b011;
      CMD_RD:  cmd_code = 3'b101;
      default: cmd_code = 3'b100;
    endcase
  endfunction

  // first command of a sequence from page class and direction
  function automatic cmd_e first_cmd(input logic [1:0] page, input logic wr);
    if (page[1])          first_cmd = CMD_PRE;
    else if (!page[0])    first_cmd = CMD_ACT;
    else if (wr)          first_cmd = CMD_WR;
    else                  first_cmd = CMD_RD;
  endfunction

endpackage

// File: rtl/sdram_seq_rst_sync.sv
module sdram_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/sdram_seq_req_latch.sv
module sdram_seq_req_latch
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        in_page,
  input  logic              in_write,
  input  logic              in_cpu,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [COL_W-1:0]  in_col,
  input  tcfg_t             in_cfg,
  output logic [1:0]        lat_page,
  output logic              lat_write,
  output logic              lat_cpu,
  output logic [ROW_W-1:0]  lat_row,
  output logic [BANK_W-1:0] lat_bank,
  output logic [COL_W-1:0]  lat_col,
  output tcfg_t             lat_cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_page  <= '0;
      lat_write <= 1'b0;
      lat_cpu   <= 1'b0;
      lat_row   <= '0;
      lat_bank  <= '0;
      lat_col   <= '0;
      lat_cfg   <= '0;
    end else if (load) begin
      lat_page  <= in_page;
      lat_write <= in_write;
      lat_cpu   <= in_cpu;
      lat_row   <= in_row;
      lat_bank  <= in_bank;
      lat_col   <= in_col;
      lat_cfg   <= in_cfg;
    end
  end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] lat_page,
  input  logic       lat_write,
  input  logic       lat_cpu,
  input  tcfg_t      lat_cfg,
  output logic       accept,
  output st_e        state,
  output cmd_e       cmd,
  output logic       rd_strobe
);
  st_e              state_n;
  cmd_e             cmd_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             cnt_zero;

  assign cnt_zero  = (cnt == '0);
  assign accept    = req_valid && (state == ST_IDLE);
  assign rd_strobe = (state == ST_DRAIN) && cnt_zero;

  always_comb begin
    state_n = state;
    cmd_n   = cmd;
    cnt_n   = cnt;
    case (state)
      ST_IDLE: if (accept) state_n = ST_WAIT1;
      ST_WAIT1: begin
        cmd_n   = first_cmd(lat_page, lat_write);
        cnt_n   = (lat_cpu && !lat_write && lat_cfg.lead4) ? CNT_W'(1) : '0;
        state_n = ST_SETUP;
      end
      ST_SETUP: begin
        if (cnt_zero) state_n = ST_ISSUE;
        else          cnt_n   = cnt - CNT_W'(1);
      end
      ST_ISSUE: begin
        case (cmd)
          CMD_PRE: begin
            cmd_n   = CMD_ACT;
            cnt_n   = lat_cfg.rp3 ? CNT_W'(1) : '0;
            state_n = ST_GAP;
          end
          CMD_ACT: begin
            cmd_n   = lat_write ? CMD_WR : CMD_RD;
            cnt_n   = lat_cfg.rcd3 ? CNT_W'(1) : '0;
            state_n = ST_GAP;
          end
          CMD_RD: begin
            cnt_n   = lat_cfg.cas3 ? CNT_W'(2) : CNT_W'(1);
            state_n = ST_DRAIN;
          end
          default: state_n = ST_IDLE;
        endcase
      end
      ST_GAP: begin
        if (cnt_zero) state_n = ST_ISSUE;
        else          cnt_n   = cnt - CNT_W'(1);
      end
      ST_DRAIN: begin
        if (cnt_zero) state_n = ST_IDLE;
        else          cnt_n   = cnt - CNT_W'(1);
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cmd   <= CMD_PRE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cmd   <= cmd_n;
      cnt   <= cnt_n;
    end
  end
endmodule

// File: rtl/sdram_seq_encode.sv
module sdram_seq_encode
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  st_e               state,
  input  cmd_e              cmd,
  input  logic [ROW_W-1:0]  lat_row,
  input  logic [COL_W-1:0]  lat_col,
  input  logic [BANK_W-1:0] lat_bank,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  addr
);
  logic       drive;
  logic [2:0] lines;

  assign drive = (state == ST_SETUP) || (state == ST_ISSUE);

  always_comb begin
    lines = 3'b111;
    addr  = '0;
    if (drive) begin
      lines = cmd_code(cmd);
      case (cmd)
        CMD_ACT:        addr = lat_row;
        CMD_RD, CMD_WR: addr = ROW_W'(lat_col);
        default:        addr = '0;
      endcase
    end
  end

  assign cs_n = (state != ST_ISSUE);
  assign {ras_n, cas_n, we_n} = lines;
  assign bank = lat_bank;
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_page,
  input  logic              req_write,
  input  logic              req_cpu,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic              cfg_cas3,
  input  logic              cfg_rcd3,
  input  logic              cfg_rp3,
  input  logic              cfg_lead4,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_bank,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              rd_valid
);
  localparam int SYNC_STAGES = 2;
  localparam int CNT_W       = 2;

  logic              rst_sync_n;
  logic              accept;
  st_e               state;
  cmd_e              cmd;
  tcfg_t             cfg_in, lat_cfg;
  logic [1:0]        lat_page;
  logic              lat_write, lat_cpu;
  logic [ROW_W-1:0]  lat_row;
  logic [BANK_W-1:0] lat_bank;
  logic [COL_W-1:0]  lat_col;

  assign cfg_in = '{cas3: cfg_cas3, rcd3: cfg_rcd3, rp3: cfg_rp3, lead4: cfg_lead4};

  sdram_seq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sdram_seq_req_latch #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_latch (
    .clk(clk), .rst_n(rst_sync_n), .load(accept),
    .in_page(req_page), .in_write(req_write), .in_cpu(req_cpu),
    .in_row(req_row), .in_bank(req_bank), .in_col(req_col), .in_cfg(cfg_in),
    .lat_page(lat_page), .lat_write(lat_write), .lat_cpu(lat_cpu),
    .lat_row(lat_row), .lat_bank(lat_bank), .lat_col(lat_col), .lat_cfg(lat_cfg)
  );

  sdram_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid),
    .lat_page(lat_page), .lat_write(lat_write), .lat_cpu(lat_cpu), .lat_cfg(lat_cfg),
    .accept(accept), .state(state), .cmd(cmd), .rd_strobe(rd_valid)
  );

  sdram_seq_encode #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_enc (
    .state(state), .cmd(cmd), .lat_row(lat_row), .lat_col(lat_col), .lat_bank(lat_bank),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .bank(sd_bank), .addr(sd_addr)
  );

  assign req_ready = (state == ST_IDLE);
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic sd_cs_n,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n,
  input logic rd_valid
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_legal_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> ({sd_ras_n, sd_cas_n, sd_we_n} inside {3'b010, 3'b011, 3'b101, 3'b100}));

  assert_cs_no_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc) || $past(acc, 2)) |-> sd_cs_n);

  assert_setup_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc, 2) |-> (sd_cs_n && ({sd_ras_n, sd_cas_n, sd_we_n} != 3'b111)));

  assert_rd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_cs_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |=> sd_cs_n);

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  assert_busy_during_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n || rd_valid) |-> !req_ready);
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_ready(req_ready),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .rd_valid(rd_valid)
);

// File: tb/sdram_cmd_seq_test.sv
`timescale 1ns/1ps
module sdram_cmd_seq_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_page;
  logic        req_write, req_cpu;
  logic [12:0] req_row;
  logic [1:0]  req_bank;
  logic [9:0]  req_col;
  logic        cfg_cas3, cfg_rcd3, cfg_rp3, cfg_lead4;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_bank;
  logic [12:0] sd_addr;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;

  sdram_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_write(req_write), .req_cpu(req_cpu),
    .req_row(req_row), .req_bank(req_bank), .req_col(req_col),
    .cfg_cas3(cfg_cas3), .cfg_rcd3(cfg_rcd3), .cfg_rp3(cfg_rp3), .cfg_lead4(cfg_lead4),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_bank(sd_bank), .sd_addr(sd_addr), .rd_valid(rd_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sd_cs_n == 1'b1,   "R1", "cs_n in reset", sd_cs_n, 1);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(rd_valid == 1'b0,  "R1", "rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sd_cs_n == 1'b1 && req_ready == 1'b1 && rd_valid == 1'b0, "R1", "idle after reset",
        {sd_cs_n, req_ready, rd_valid}, 3'b110);
  endtask

  task automatic do_access(input logic [1:0] pg, input logic wr, input logic cpu,
                           input logic c_cl, input logic c_rcd, input logic c_rp, input logic c_ld,
                           input logic [12:0] row, input logic [1:0] bk, input logic [9:0] col);
    int          lead, t, n, erd, erdy, gn, rd_first, rd_cnt, early, err0;
    int          ecyc[3], gcyc[3];
    logic [2:0]  ecmd[3], gcmd[3], setup_lines;
    logic [12:0] eadr[3], gadr[3];
    logic [1:0]  gbk[3];
    logic        setup_cs, rdy_last;
    string       ptag;
    err0 = errors;
    ptag = pg[1] ? "R5" : (pg[0] ? "R3" : "R4");
    lead = (cpu && !wr && c_ld) ? 4 : 3;
    t = lead; n = 0;
    if (pg[1]) begin
      ecyc[n] = t; ecmd[n] = 3'b010; eadr[n] = '0; n++;
      t += c_rp ? 3 : 2;
    end
    if (pg[1] || !pg[0]) begin
      ecyc[n] = t; ecmd[n] = 3'b011; eadr[n] = row; n++;
      t += c_rcd ? 3 : 2;
    end
    ecyc[n] = t; ecmd[n] = wr ? 3'b100 : 3'b101; eadr[n] = {3'b000, col}; n++;
    erd  = wr ? -1 : t + (c_cl ? 3 : 2);
    erdy = wr ? t + 1 : erd + 1;

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_page = pg; req_write = wr; req_cpu = cpu;
    req_row = row; req_bank = bk; req_col = col;
    cfg_cas3 = c_cl; cfg_rcd3 = c_rcd; cfg_rp3 = c_rp; cfg_lead4 = c_ld;
    @(posedge clk);
    gn = 0; rd_first = -1; rd_cnt = 0; early = 0; rdy_last = 1'b0;
    setup_cs = 1'b0; setup_lines = 3'b000;
    for (int k = 1; k <= erdy; k++) begin
      @(negedge clk);
      if (k == 2) begin setup_cs = sd_cs_n; setup_lines = {sd_ras_n, sd_cas_n, sd_we_n}; end
      if (!sd_cs_n) begin
        if (gn < 3) begin
          gcyc[gn] = k; gcmd[gn] = {sd_ras_n, sd_cas_n, sd_we_n};
          gadr[gn] = sd_addr; gbk[gn] = sd_bank;
        end
        gn++;
      end
      if (rd_valid) begin
        if (rd_first < 0) rd_first = k;
        rd_cnt++;
      end
      if (k < erdy && req_ready) early++;
      if (k == erdy) rdy_last = req_ready;
      if (k == 1) begin
        req_valid = 1'b0;
        cfg_cas3 = ~c_cl; cfg_rcd3 = ~c_rcd; cfg_rp3 = ~c_rp; cfg_lead4 = ~c_ld;
        req_row = ~row; req_col = ~col; req_page = ~pg; req_write = ~wr;
      end
    end

    chk(setup_cs == 1'b1 && setup_lines == ecmd[0], "R7", "clock 2 cs_n/lines",
        {setup_cs, setup_lines}, {1'b1, ecmd[0]});
    chk(gn == n, "R9", "command count", gn, n);
    if (gn >= 1) chk(gcyc[0] == lead, "R6", "first cs clock", gcyc[0], lead);
    for (int i = 0; i < n && i < gn; i++) begin
      chk(gcyc[i] == ecyc[i], ptag, "command clock", gcyc[i], ecyc[i]);
      chk(gcmd[i] == ecmd[i], "R2", "command code", gcmd[i], ecmd[i]);
      chk(gadr[i] == eadr[i], ptag, "command address", gadr[i], eadr[i]);
      chk(gbk[i] == bk, ptag, "command bank", gbk[i], bk);
    end
    chk(rd_cnt == (wr ? 0 : 1), "R8", "rd_valid pulse count", rd_cnt, wr ? 0 : 1);
    if (!wr) chk(rd_first == erd, "R8", "rd_valid clock", rd_first, erd);
    chk(early == 0, "R11", "ready high while busy", early, 0);
    chk(rdy_last == 1'b1, "R11", "ready back at end", rdy_last, 1);
    chk(errors == err0, "R10", "access altered by mid-access setting change", errors - err0, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_page = 2'b00; req_write = 1'b0; req_cpu = 1'b0;
    req_row = '0; req_bank = '0; req_col = '0;
    cfg_cas3 = 1'b0; cfg_rcd3 = 1'b0; cfg_rp3 = 1'b0; cfg_lead4 = 1'b0;
    check_reset();
    // hit reads, fastest and slowest leadoff/latency (R3 R6 R8)
    do_access(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 13'h1A5A, 2'd1, 10'h2C3);
    do_access(2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 13'h0F0F, 2'd2, 10'h3FF);
    // hit write: leadoff setting does not apply (R6)
    do_access(2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 13'h1234, 2'd3, 10'h155);
    // non-CPU read with lead4 set stays at clock 3 (R6)
    do_access(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 13'h0001, 2'd0, 10'h001);
    // idle bank (R4)
    do_access(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 13'h1FFF, 2'd2, 10'h0AA);
    do_access(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 13'h0800, 2'd1, 10'h200);
    do_access(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 13'h0555, 2'd3, 10'h111);
    // miss (R5), both encodings, corner timings
    do_access(2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 13'h1ABC, 2'd0, 10'h3C3);
    do_access(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 13'h0246, 2'd1, 10'h010);
    do_access(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 13'h1357, 2'd2, 10'h2A5);
    do_access(2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 13'h0ACE, 2'd3, 10'h0FF);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule